// File: doc/BRIEF.md
# Disk Command and Status Unit

This block is the programmed-I/O front end of a head-per-track disk controller attached to a 12-bit processor bus. Each bus I/O instruction is presented as a strobe, a three-bit device subcode and a three-bit pulse field. The block decodes these fields. It keeps a 12-bit status word and a 20-bit disk address. In the cycle of the strobe it returns a skip flag and the new accumulator value. It merges three interrupt sources into a single request and issues start-read and start-write commands.

The transfer engine, the rotational timer and main memory sit outside the block. They reach it only through a few inputs: a done pulse, error-set pulses, a photocell level and a platter-count setting. The engine takes the disk address from the block's address output.

Top module: `diskIotUnit`

## Requirements
- R1: After reset, the status word reads 0 (while photoIn is low), both address halves read 0, the done flag is set and intReq is low.
- R2: intReq is high exactly when any of these holds: done with done-enable (status bit 6); any error with error-enable (bit 8); photocell (bit 11) with photocell-enable (bit 7). The error bits are write-lock (bit 9), data-late (bit 2), non-existent-disk (bit 1) and parity (bit 0).
- R3: Subcode 0 with pulse bit 0 clears address bits 11:0, the done flag and all four error bits.
- R4: Subcode 0 with pulse bit 1 or bit 2 does four things. It ORs accIn into address bits 11:0, after the clear of R3 when bit 0 is also set. It returns 0 on accOut. It pulses startWrite in the next cycle if pulse bit 2 is set, and startRead otherwise.
- R5: Subcode 1 pulse 1 keeps only the status bits under mask 07007 (octal). intReq is low in the next cycle.
- R6: Subcode 1 pulse 5 keeps the status bits under 07007 and loads the bits under 0770 from accIn. It returns 0. Subcode 1 pulse 6 returns the whole status word.
- R7: Subcode 2 skips when pulse bit 0 is set and any error is present. It also skips when pulse bit 1 is set without bit 2 and done is set.
- R8: Subcode 2 with pulse bit 2 returns address bits 11:0 ORed into accIn, or into 0 when pulse bit 1 is also set.
- R9: Subcode 4 loads address bits 19:12 from accIn[7:0]. Pulse 1 clears them, pulse 2 ORs, and pulse 3 clears then ORs. Pulses 2 and 3 return 0.
- R10: Subcode 4 pulse 5 returns address bits 19:12 zero-extended. Pulse 4 ORs them into accIn.
- R11: After every subcode-4 strobe, non-existent-disk (bit 1) is set when the new address is at or beyond (platters+1)*262144 words, and cleared otherwise.
- R12: A xferDone pulse sets done. errSet[0..3] set parity, non-existent-disk, data-late and write-lock. Status bit 11 follows photoIn one cycle late.
- R13: Subcodes 3, 5, 6 and 7, and the pulse values not listed above, pass accIn to accOut, do not skip and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| iotStrobe | input | 1 | I/O instruction valid this cycle |
| iotSub | input | 3 | Device subcode |
| iotPulse | input | 3 | Pulse field |
| accIn | input | 12 | Accumulator from the processor |
| accOut | output | 12 | Accumulator returned, valid with the strobe |
| skip | output | 1 | Skip request, valid with the strobe |
| xferDone | input | 1 | Transfer engine finished |
| errSet | input | 4 | Error set pulses: parity, no-disk, data-late, write-lock |
| photoIn | input | 1 | Photocell level from the rotational timer |
| platters | input | 2 | Installed platter count minus one |
| intReq | output | 1 | Interrupt request |
| startRead | output | 1 | One-cycle start of a read transfer |
| startWrite | output | 1 | One-cycle start of a write transfer |
| diskAddr | output | 20 | Current disk word address |

## Verification
The embedded properties check four things on every cycle. Start commands never overlap, and each traces back to a subcode-0 strobe. The non-existent-disk bit matches the capacity compare after every extended-address command. The clear and mask commands leave done, the errors and the interrupt request low.

The full interrupt equation over all enable and source combinations, the masked status loads, the OR-versus-clear address loading and the inertness of unused codes are shown only by the bench's sweeps. The bench compares returned accumulator values against its own model of the requirements.

// File: rtl/diskIotPkg.sv
package diskIotPkg;
  localparam int STA_W = 12;
  localparam int ST_PHOTO = 11;
  localparam int ST_WLK   = 9;
  localparam int ST_EIE   = 8;
  localparam int ST_PIE   = 7;
  localparam int ST_CIE   = 6;
  localparam int ST_LATE  = 2;
  localparam int ST_NXD   = 1;
  localparam int ST_PAR   = 0;
  localparam logic [STA_W-1:0] KEEP_MASK = 12'o7007;
  localparam logic [STA_W-1:0] LOAD_MASK = 12'o0770;
  localparam logic [STA_W-1:0] ERR_MASK  = 12'o1007;

  typedef enum logic [2:0] {
    ACC_PASS, ACC_ZERO, ACC_STATUS, ACC_LOW_OR, ACC_LOW_ONLY, ACC_HI_OR, ACC_HI_ONLY
  } accSel_e;

  typedef struct packed {
    logic    clrLow;
    logic    orLow;
    logic    clrHi;
    logic    orHi;
    logic    clrDoneErr;
    logic    maskSta;
    logic    loadEn;
    logic    checkNxd;
    logic    skipErr;
    logic    skipDone;
    accSel_e accSel;
  } iotCmd_t;
endpackage

// File: rtl/diskIotCtrl.sv
module diskIotCtrl
  import diskIotPkg::*;
#(
  parameter int SUB_W   = 3,
  parameter int PULSE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               iotStrobe,
  input  logic [SUB_W-1:0]   iotSub,
  input  logic [PULSE_W-1:0] iotPulse,
  output iotCmd_t            cmd,
  output logic               startRead,
  output logic               startWrite
);
  logic isStart;

  always_comb begin
    cmd = '0;
    cmd.accSel = ACC_PASS;
    if (iotStrobe) begin
      case (iotSub)
        SUB_W'(0): begin
          cmd.clrLow     = iotPulse[0];
          cmd.clrDoneErr = iotPulse[0];
          if (iotPulse[1] | iotPulse[2]) begin
            cmd.orLow  = 1'b1;
            cmd.accSel = ACC_ZERO;
          end
        end
        SUB_W'(1): begin
          case (iotPulse)
            PULSE_W'(1): cmd.maskSta = 1'b1;
            PULSE_W'(5): begin
              cmd.maskSta = 1'b1;
              cmd.loadEn  = 1'b1;
              cmd.accSel  = ACC_ZERO;
            end
            PULSE_W'(6): cmd.accSel = ACC_STATUS;
            default: ;
          endcase
        end
        SUB_W'(2): begin
          cmd.skipErr  = iotPulse[0];
          cmd.skipDone = iotPulse[1] & ~iotPulse[2];
          if (iotPulse[2]) cmd.accSel = iotPulse[1] ? ACC_LOW_ONLY : ACC_LOW_OR;
        end
        SUB_W'(4): begin
          cmd.checkNxd = 1'b1;
          case (iotPulse)
            PULSE_W'(1): cmd.clrHi = 1'b1;
            PULSE_W'(3): begin
              cmd.clrHi  = 1'b1;
              cmd.orHi   = 1'b1;
              cmd.accSel = ACC_ZERO;
            end
            PULSE_W'(2): begin
              cmd.orHi   = 1'b1;
              cmd.accSel = ACC_ZERO;
            end
            PULSE_W'(5): cmd.accSel = ACC_HI_ONLY;
            PULSE_W'(4): cmd.accSel = ACC_HI_OR;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign isStart = iotStrobe && (iotSub == SUB_W'(0)) && (iotPulse[1] | iotPulse[2]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startRead  <= 1'b0;
      startWrite <= 1'b0;
    end else begin
      startRead  <= isStart & ~iotPulse[2];
      startWrite <= isStart & iotPulse[2];
    end
  end

  assert_start_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startRead, startWrite}));
  assert_write_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    startWrite |-> $past(iotStrobe && iotSub == SUB_W'(0) && iotPulse[2]));
  assert_read_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    startRead |-> $past(iotStrobe && iotSub == SUB_W'(0) && iotPulse[1] && !iotPulse[2]));
endmodule

// File: rtl/diskIotData.sv
module diskIotData
  import diskIotPkg::*;
#(
  parameter int ACC_W  = STA_W,
  parameter int HI_W   = 8,
  parameter int PLAT_W = 2,
  localparam int ADDR_W = ACC_W + HI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  iotCmd_t           cmd,
  input  logic [ACC_W-1:0]  accIn,
  input  logic              xferDone,
  input  logic [3:0]        errSet,
  input  logic              photoIn,
  input  logic [PLAT_W-1:0] platters,
  output logic [ACC_W-1:0]  accOut,
  output logic              skip,
  output logic              intReq,
  output logic [ADDR_W-1:0] diskAddr
);
  logic [ACC_W-1:0]  lowQ, lowD;
  logic [HI_W-1:0]   hiQ, hiD;
  logic [ADDR_W-1:0] addrD;
  logic [STA_W-1:0]  staQ, staD;
  logic              doneQ, doneD;
  logic              errAny;
  logic [ACC_W-1:0]  hiWide;

  assign errAny   = |(staQ & ERR_MASK);
  assign hiWide   = {{(ACC_W-HI_W){1'b0}}, hiQ};
  assign diskAddr = {hiQ, lowQ};

  always_comb begin
    lowD = cmd.clrLow ? '0 : lowQ;
    if (cmd.orLow) lowD = lowD | accIn;
    hiD = cmd.clrHi ? '0 : hiQ;
    if (cmd.orHi) hiD = hiD | accIn[HI_W-1:0];
    addrD = {hiD, lowD};

    staD = staQ;
    if (cmd.maskSta) staD = (staQ & KEEP_MASK) | (cmd.loadEn ? (accIn & LOAD_MASK) : '0);
    if (cmd.clrDoneErr) staD = staD & ~ERR_MASK;
    if (cmd.checkNxd) staD[ST_NXD] = (addrD[ADDR_W-1 -: PLAT_W] > platters);
    staD[ST_PAR]   = staD[ST_PAR]  | errSet[0];
    staD[ST_NXD]   = staD[ST_NXD]  | errSet[1];
    staD[ST_LATE]  = staD[ST_LATE] | errSet[2];
    staD[ST_WLK]   = staD[ST_WLK]  | errSet[3];
    staD[ST_PHOTO] = photoIn;

    doneD = xferDone | (doneQ & ~cmd.clrDoneErr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowQ  <= '0;
      hiQ   <= '0;
      staQ  <= '0;
      doneQ <= 1'b1;
    end else begin
      lowQ  <= lowD;
      hiQ   <= hiD;
      staQ  <= staD;
      doneQ <= doneD;
    end
  end

  always_comb begin
    case (cmd.accSel)
      ACC_ZERO:     accOut = '0;
      ACC_STATUS:   accOut = staQ;
      ACC_LOW_OR:   accOut = accIn | lowQ;
      ACC_LOW_ONLY: accOut = lowQ;
      ACC_HI_OR:    accOut = accIn | hiWide;
      ACC_HI_ONLY:  accOut = hiWide;
      default:      accOut = accIn;
    endcase
  end

  assign skip   = (cmd.skipErr & errAny) | (cmd.skipDone & doneQ);
  assign intReq = (doneQ & staQ[ST_CIE]) | (errAny & staQ[ST_EIE]) |
                  (staQ[ST_PHOTO] & staQ[ST_PIE]);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.clrDoneErr && !cmd.orLow && !xferDone && errSet == 4'b0)
      |=> (!doneQ && !errAny && lowQ == '0));
  assert_start_acc_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.orLow |-> accOut == '0);
  assert_mask_int_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.maskSta && !cmd.loadEn) |=> !intReq);
  assert_capacity_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.checkNxd && !errSet[1])
      |=> staQ[ST_NXD] == (diskAddr[ADDR_W-1 -: PLAT_W] > $past(platters)));
  assert_done_set_R12: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> doneQ);
endmodule

// File: rtl/diskIotUnit.sv
module diskIotUnit
  import diskIotPkg::*;
#(
  parameter int SUB_W   = 3,
  parameter int PULSE_W = 3,
  parameter int ACC_W   = STA_W,
  parameter int HI_W    = 8,
  parameter int PLAT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    iotStrobe,
  input  logic [SUB_W-1:0]        iotSub,
  input  logic [PULSE_W-1:0]      iotPulse,
  input  logic [ACC_W-1:0]        accIn,
  output logic [ACC_W-1:0]        accOut,
  output logic                    skip,
  input  logic                    xferDone,
  input  logic [3:0]              errSet,
  input  logic                    photoIn,
  input  logic [PLAT_W-1:0]       platters,
  output logic                    intReq,
  output logic                    startRead,
  output logic                    startWrite,
  output logic [ACC_W+HI_W-1:0]   diskAddr
);
  iotCmd_t cmd;

  diskIotCtrl #(.SUB_W(SUB_W), .PULSE_W(PULSE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .iotStrobe(iotStrobe), .iotSub(iotSub),
    .iotPulse(iotPulse), .cmd(cmd), .startRead(startRead), .startWrite(startWrite)
  );

  diskIotData #(.ACC_W(ACC_W), .HI_W(HI_W), .PLAT_W(PLAT_W)) i_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .accIn(accIn), .xferDone(xferDone),
    .errSet(errSet), .photoIn(photoIn), .platters(platters), .accOut(accOut),
    .skip(skip), .intReq(intReq), .diskAddr(diskAddr)
  );
endmodule

// File: tb/test_diskIotUnit.sv
module test_diskIotUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        iotStrobe = 1'b0;
  logic [2:0]  iotSub = '0;
  logic [2:0]  iotPulse = '0;
  logic [11:0] accIn = '0;
  logic [11:0] accOut;
  logic        skip;
  logic        xferDone = 1'b0;
  logic [3:0]  errSet = '0;
  logic        photoIn = 1'b0;
  logic [1:0]  platters = '0;
  logic        intReq;
  logic        startRead;
  logic        startWrite;
  logic [19:0] diskAddr;

  int nChecks = 0;
  int nErrors = 0;

  logic [11:0] mSta;
  logic [19:0] mDa;
  logic        mDone;

  always #4 clk = ~clk;

  diskIotUnit i_diskIotUnit (
    .clk(clk), .rstN(rstN), .iotStrobe(iotStrobe), .iotSub(iotSub), .iotPulse(iotPulse),
    .accIn(accIn), .accOut(accOut), .skip(skip), .xferDone(xferDone), .errSet(errSet),
    .photoIn(photoIn), .platters(platters), .intReq(intReq), .startRead(startRead),
    .startWrite(startWrite), .diskAddr(diskAddr)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
    end
  endtask

  function automatic logic modelInt();
    logic e;
    e = mSta[9] | mSta[2] | mSta[1] | mSta[0];
    return (mDone & mSta[6]) | (e & mSta[8]) | (mSta[11] & mSta[7]);
  endfunction

  task automatic iot(input logic [2:0] sub, input logic [2:0] pul, input logic [11:0] ac,
                     input string tag);
    logic [11:0] expAcc;
    logic expSkip, expRd, expWr, errAny;
    expAcc = ac; expSkip = 1'b0; expRd = 1'b0; expWr = 1'b0;
    errAny = mSta[9] | mSta[2] | mSta[1] | mSta[0];
    case (sub)
      3'd0: begin
        if (pul[0]) begin mDa[11:0] = '0; mDone = 1'b0; mSta = mSta & ~12'o1007; end
        if (pul[1] | pul[2]) begin
          mDa[11:0] = mDa[11:0] | ac; expAcc = '0; expWr = pul[2]; expRd = ~pul[2];
        end
      end
      3'd1: begin
        if (pul == 3'd1) mSta = mSta & 12'o7007;
        else if (pul == 3'd5) begin mSta = (mSta & 12'o7007) | (ac & 12'o0770); expAcc = '0; end
        else if (pul == 3'd6) expAcc = mSta;
      end
      3'd2: begin
        expSkip = (pul[0] & errAny) | (pul[1] & ~pul[2] & mDone);
        if (pul[2]) expAcc = (pul[1] ? 12'd0 : ac) | mDa[11:0];
      end
      3'd4: begin
        case (pul)
          3'd1: mDa[19:12] = '0;
          3'd3: begin mDa[19:12] = ac[7:0]; expAcc = '0; end
          3'd2: begin mDa[19:12] = mDa[19:12] | ac[7:0]; expAcc = '0; end
          3'd5: expAcc = {4'd0, mDa[19:12]};
          3'd4: expAcc = ac | {4'd0, mDa[19:12]};
          default: ;
        endcase
        mSta[1] = (mDa[19:18] > platters);
      end
      default: ;
    endcase
    @(negedge clk);
    iotStrobe = 1'b1; iotSub = sub; iotPulse = pul; accIn = ac;
    #1;
    chk(accOut, expAcc, {tag, " accOut"});
    chk(skip, expSkip, {tag, " skip"});
    @(posedge clk);
    #1;
    iotStrobe = 1'b0;
    chk(startRead, expRd, {tag, " startRead"});
    chk(startWrite, expWr, {tag, " startWrite"});
    chk(intReq, modelInt(), {tag, " intReq"});
    chk(diskAddr, mDa, {tag, " diskAddr"});
  endtask

  task automatic pulseDone();
    @(negedge clk); xferDone = 1'b1;
    @(posedge clk); #1 xferDone = 1'b0;
    mDone = 1'b1;
  endtask

  task automatic pulseErr(input int idx);
    @(negedge clk); errSet = 4'b1 << idx;
    @(posedge clk); #1 errSet = '0;
    case (idx)
      0: mSta[0] = 1'b1;
      1: mSta[1] = 1'b1;
      2: mSta[2] = 1'b1;
      default: mSta[9] = 1'b1;
    endcase
  endtask

  task automatic setPhoto(input logic v);
    @(negedge clk); photoIn = v;
    @(posedge clk); #1;
    mSta[11] = v;
  endtask

  initial begin
    #(8 * 150000);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    mSta = '0; mDa = '0; mDone = 1'b1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    chk(intReq, 1'b0, "R1 intReq after reset");
    chk(diskAddr, 20'd0, "R1 address after reset");
    iot(3'd1, 3'd6, 12'o5555, "R1 status read");
    iot(3'd4, 3'd5, 12'o1234, "R1 high address read");
    iot(3'd2, 3'd2, 12'o0, "R1 done skip");

    // R12: engine events and photocell
    for (int i = 0; i < 4; i++) begin
      iot(3'd0, 3'd1, 12'o0, "R3 clear before error");
      pulseErr(i);
      iot(3'd1, 3'd6, 12'o0, "R12 error bit readback");
      iot(3'd2, 3'd1, 12'o0, "R7 error skip");
    end
    iot(3'd0, 3'd1, 12'o0, "R3 clear errors");
    iot(3'd2, 3'd1, 12'o0, "R7 no error no skip");
    iot(3'd2, 3'd2, 12'o0, "R7 done cleared no skip");
    pulseDone();
    iot(3'd2, 3'd2, 12'o0, "R12 done set skip");
    iot(3'd2, 3'd3, 12'o0, "R7 combined skip");
    setPhoto(1'b1);
    iot(3'd1, 3'd6, 12'o0, "R12 photocell bit");
    setPhoto(1'b0);

    // R6: masked status loads
    for (int v = 0; v < 64; v++) begin
      iot(3'd1, 3'd5, 12'((v << 3) | 12'o7007), "R6 masked load");
      iot(3'd1, 3'd6, 12'o0, "R6 status read");
    end

    // R2 and R5: interrupt equation sweep
    for (int e = 0; e < 8; e++) begin
      for (int c = 0; c < 8; c++) begin
        setPhoto(c[2]);
        iot(3'd0, 3'd1, 12'o0, "R3 clear for int sweep");
        if (c[0]) pulseDone();
        if (c[1]) pulseErr(2);
        iot(3'd1, 3'd5, 12'({e[2], e[1], e[0], 6'b0}), "R2 int equation");
        iot(3'd1, 3'd1, 12'o0, "R5 mask drops int");
        chk(intReq, 1'b0, "R5 intReq low after mask");
        iot(3'd1, 3'd6, 12'o0, "R5 status after mask");
      end
    end
    setPhoto(1'b0);

    // R3, R4, R8: low address and start commands
    iot(3'd0, 3'd1, 12'o7777, "R3 clear low");
    iot(3'd0, 3'd2, 12'o1234, "R4 read start");
    iot(3'd0, 3'd4, 12'o0070, "R4 write start OR");
    iot(3'd2, 3'd4, 12'o5000, "R8 low OR return");
    iot(3'd2, 3'd6, 12'o5000, "R8 low only return");
    iot(3'd0, 3'd3, 12'o0707, "R4 clear then read");
    iot(3'd0, 3'd6, 12'o0001, "R4 both bits write");
    iot(3'd0, 3'd7, 12'o4000, "R4 clear then write");
    iot(3'd2, 3'd6, 12'o0, "R8 low readback");

    // R9, R10, R11: high address and capacity sweep
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); platters = 2'(p);
      for (int h = 0; h < 256; h++) begin
        iot(3'd4, 3'd3, 12'(h | 12'o7400), "R11 capacity load");
        iot(3'd1, 3'd6, 12'o0, "R11 nxd status");
      end
      iot(3'd4, 3'd1, 12'o0, "R9 clear high");
      iot(3'd4, 3'd2, 12'o0201, "R9 OR high");
      iot(3'd4, 3'd2, 12'o0104, "R9 OR high again");
      iot(3'd4, 3'd5, 12'o7777, "R10 high only");
      iot(3'd4, 3'd4, 12'o7000, "R10 high OR");
    end

    // R13: unused codes
    for (int s = 0; s < 8; s++) begin
      for (int q = 0; q < 8; q++) begin
        if (s == 3 || s >= 5 || (s == 1 && !(q == 1 || q == 5 || q == 6)) ||
            (s == 4 && (q == 0 || q >= 6)) || (s == 2 && q == 0))
          iot(3'(s), 3'(q), 12'o6543, "R13 unused code");
      end
    end
    iot(3'd1, 3'd6, 12'o0, "R13 status unchanged");
    iot(3'd2, 3'd6, 12'o0, "R13 low unchanged");
    iot(3'd4, 3'd5, 12'o0, "R13 high unchanged");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule